// File: doc/BRIEF.md
# Byte FIFO with Occupancy Threshold Flags

This block is a circular byte buffer that sits between a host register port and a serial transfer engine. The host pushes bytes for transmission and pops received bytes through its data port. The engine pushes the bytes it receives and pops the bytes it sends. The depth is a parameter and may be 8, 16, 32 or 64 bytes. Internally a small state machine tracks the fill state: EMPTY, PARTIAL and FULL. The transitions are EMPTY to PARTIAL on an accepted push, PARTIAL to FULL when a push brings the occupancy to the depth, FULL to PARTIAL on a pop, PARTIAL to EMPTY on the pop of the last byte, and any state to EMPTY on a clear command.

A configuration write loads two 6-bit thresholds and can empty the buffer at the same time. The receive threshold sits in bits 13:8 of the configuration word and the transmit threshold in bits 5:0. Setting bit 14 or bit 6 of that word requests a clear. The block compares occupancy against the receive threshold to decide between a "ready" indication, which means a full burst of data is waiting, and a "drain" indication, which means only a tail remains. On the transmit side it makes the same choice from the engine's remaining byte count. The block also keeps sticky indications for access errors, access completion and transmit underflow. It also presents a 16-bit buffer-status word.

Top module: `xfer_byte_fifo`

## Requirements
- R1: Bytes leave in the order they entered, across pointer wrap-around. Up to DEPTH bytes are held.
- R2: A host write to a full buffer drops the byte and sets `acc_err`. A host read of an empty buffer sets `acc_err`. Any successful host read or write clears `acc_err`.
- R3: An engine pop of an empty buffer sets `tx_underflow`. A successful host write clears it.
- R4: On an `eng_rx_done` pulse, the block clears both receive flags first. It then sets `rx_ready` when occupancy is greater than the receive threshold, and sets `rx_drain` otherwise.
- R5: After a successful host read that leaves a non-zero occupancy at or below the receive threshold, `rx_ready` is 0 and `rx_drain` is 1. A read that leaves the occupancy above the threshold leaves both flags unchanged.
- R6: A host read that empties the buffer clears `rx_ready` and `rx_drain` and sets `acc_ready`. A successful host write or an `eng_rx_done` pulse clears `acc_ready`.
- R7: One cycle after `xfer_tx` is high with `xfer_left` non-zero and the buffer empty, `tx_ready` equals (`xfer_left` > transmit threshold) and `tx_drain` is its complement. In every other case both are 0.
- R8: A configuration write with bit 14 or bit 6 set empties the buffer. A configuration write with neither bit set keeps the contents.
- R9: `buf_status` bits 15:14 hold the size code (8 gives 0, 16 gives 1, 32 gives 2, 64 gives 3). Bits 13:8 hold the occupancy modulo 64. Bits 7:6 are 0. Bits 5:0 hold `xfer_left` bits 5:0.
- R10: When host and engine push in the same cycle, only the host byte is stored. When both pop in the same cycle, only one byte is removed.
- R11: After reset the buffer is empty, both thresholds are 0 and every flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host push strobe |
| host_wdata | input | 8 | Host push byte |
| host_rd | input | 1 | Host pop strobe |
| host_rdata | output | 8 | Head byte, valid while popping |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Thresholds and clear bits |
| eng_push | input | 1 | Engine receive push strobe |
| eng_wdata | input | 8 | Engine receive byte |
| eng_pop | input | 1 | Engine transmit pop strobe |
| eng_rdata | output | 8 | Head byte for the engine |
| eng_rx_done | input | 1 | Engine finished a receive fill |
| xfer_tx | input | 1 | Transfer direction is transmit |
| xfer_left | input | 16 | Bytes still owed in the transfer |
| rx_ready | output | 1 | Receive burst available |
| rx_drain | output | 1 | Receive tail available |
| tx_ready | output | 1 | Transmit burst wanted |
| tx_drain | output | 1 | Transmit tail wanted |
| acc_ready | output | 1 | Buffer emptied by host reads |
| acc_err | output | 1 | Host access error |
| tx_underflow | output | 1 | Engine popped an empty buffer |
| buf_status | output | 16 | Size code, occupancy, remaining count |

## Verification
The threshold decision is swept over every receive threshold from 0 to 8 against every fill level from 0 to 8. This separates the strict "greater than" comparison from "at or above". A full drain is read down one byte at a time for each threshold, which shows exactly where drain takes over from ready and where the empty case takes over. The transmit decision is swept over remaining counts 0 to 8 against several thresholds, both with the buffer empty and with it holding data. Repeated partial fill-and-drain rounds move the pointers across the wrap point. Collision patterns, such as a full write, an empty read, simultaneous pushes and simultaneous pops, separate the error, drop and priority rules.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;
    typedef enum logic [1:0] {
        FS_EMPTY   = 2'd0,
        FS_PARTIAL = 2'd1,
        FS_FULL    = 2'd2
    } fill_state_e;

    function automatic logic [1:0] size_code(input int depth);
        case (depth)
            16:      return 2'd1;
            32:      return 2'd2;
            64:      return 2'd3;
            default: return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/xfer_byte_ring.sv
module xfer_byte_ring
    import xfer_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          full
);
    logic [7:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    fill_state_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            level <= level + LW'(push) - LW'(pop);
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            FS_EMPTY:   if (push) state_nxt = FS_PARTIAL;
            FS_PARTIAL: begin
                if (push && !pop && level == LW'(DEPTH - 1)) state_nxt = FS_FULL;
                else if (pop && !push && level == LW'(1))    state_nxt = FS_EMPTY;
            end
            FS_FULL:    if (pop && !push) state_nxt = FS_PARTIAL;
            default:    state_nxt = FS_EMPTY;
        endcase
        if (clr) state_nxt = FS_EMPTY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FS_EMPTY;
        else        state <= state_nxt;
    end

    always_comb begin
        empty = (state == FS_EMPTY);
        full  = (state == FS_FULL);
        head  = mem[rd_ptr];
    end

    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    a_r1_state_matches_level: assert property (@(posedge clk) disable iff (!rst_n)
        (empty == (level == '0)) && (full == (level == LW'(DEPTH))));
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (level == '0) && empty);
endmodule

// File: rtl/xfer_flag_ctrl.sv
module xfer_flag_ctrl #(
    parameter int LW = 4,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_push_ok,
    input  logic          h_push_err,
    input  logic          h_pop_ok,
    input  logic          h_pop_err,
    input  logic          e_pop_err,
    input  logic          rx_eval,
    input  logic [LW-1:0] level,
    input  logic [5:0]    rx_thr,
    input  logic [5:0]    tx_thr,
    input  logic          xfer_tx,
    input  logic [CW-1:0] xfer_left,
    input  logic          empty,
    output logic          rx_ready,
    output logic          rx_drain,
    output logic          tx_ready,
    output logic          tx_drain,
    output logic          acc_ready,
    output logic          acc_err,
    output logic          tx_underflow
);
    logic [6:0] lvl_w, after_rd, thr_w;
    logic rr_n, rd_n, ar_n, ae_n, uf_n, tx_need;

    always_comb begin
        lvl_w    = 7'(level);
        after_rd = lvl_w - 7'd1;
        thr_w    = 7'(rx_thr);
        rr_n = rx_ready;
        rd_n = rx_drain;
        ar_n = acc_ready;
        ae_n = acc_err;
        uf_n = tx_underflow;
        if (h_pop_ok) begin
            if (after_rd == 7'd0) begin
                rr_n = 1'b0;
                rd_n = 1'b0;
                ar_n = 1'b1;
            end else if (after_rd <= thr_w) begin
                rr_n = 1'b0;
                rd_n = 1'b1;
            end
        end
        if (rx_eval) begin
            rr_n = (lvl_w > thr_w);
            rd_n = !(lvl_w > thr_w);
            ar_n = 1'b0;
        end
        if (h_push_ok) begin
            ar_n = 1'b0;
            uf_n = 1'b0;
        end
        if (h_push_ok || h_pop_ok)   ae_n = 1'b0;
        if (h_push_err || h_pop_err) ae_n = 1'b1;
        if (e_pop_err)               uf_n = 1'b1;
        tx_need = xfer_tx && (xfer_left != '0) && empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_ready     <= 1'b0;
            rx_drain     <= 1'b0;
            tx_ready     <= 1'b0;
            tx_drain     <= 1'b0;
            acc_ready    <= 1'b0;
            acc_err      <= 1'b0;
            tx_underflow <= 1'b0;
        end else begin
            rx_ready     <= rr_n;
            rx_drain     <= rd_n;
            tx_ready     <= tx_need && (xfer_left > CW'(tx_thr));
            tx_drain     <= tx_need && !(xfer_left > CW'(tx_thr));
            acc_ready    <= ar_n;
            acc_err      <= ae_n;
            tx_underflow <= uf_n;
        end
    end

    a_r4_rx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_ready, rx_drain}));
    a_r7_tx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_ready, tx_drain}));
    a_r3_underflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (e_pop_err && !h_push_ok) |=> tx_underflow);
    a_r6_empty_read_done: assert property (@(posedge clk) disable iff (!rst_n)
        (h_pop_ok && level == LW'(1) && !rx_eval) |=> acc_ready && !rx_ready && !rx_drain);
endmodule

// File: rtl/xfer_byte_fifo.sv
module xfer_byte_fifo
    import xfer_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 16,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic [7:0]    host_wdata,
    input  logic          host_rd,
    output logic [7:0]    host_rdata,
    input  logic          cfg_wr,
    input  logic [15:0]   cfg_wdata,
    input  logic          eng_push,
    input  logic [7:0]    eng_wdata,
    input  logic          eng_pop,
    output logic [7:0]    eng_rdata,
    input  logic          eng_rx_done,
    input  logic          xfer_tx,
    input  logic [CW-1:0] xfer_left,
    output logic          rx_ready,
    output logic          rx_drain,
    output logic          tx_ready,
    output logic          tx_drain,
    output logic          acc_ready,
    output logic          acc_err,
    output logic          tx_underflow,
    output logic [15:0]   buf_status
);
    localparam logic [1:0] SZ_CODE = size_code(DEPTH);

    logic [5:0]    rx_thr, tx_thr;
    logic [LW-1:0] level;
    logic [7:0]    head;
    logic empty, full, clr;
    logic h_push_ok, h_push_err, e_push_ok;
    logic h_pop_ok, h_pop_err, e_pop_ok, e_pop_err;

    always_comb begin
        clr        = cfg_wr && (cfg_wdata[14] || cfg_wdata[6]);
        h_push_ok  = host_wr && !full;
        h_push_err = host_wr && full;
        e_push_ok  = eng_push && !host_wr && !full;
        h_pop_ok   = host_rd && !empty;
        h_pop_err  = host_rd && empty;
        e_pop_ok   = eng_pop && !host_rd && !empty;
        e_pop_err  = eng_pop && !host_rd && empty;
        host_rdata = head;
        eng_rdata  = head;
        buf_status = {SZ_CODE, 6'(level), 2'b00, xfer_left[5:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_thr <= '0;
            tx_thr <= '0;
        end else if (cfg_wr) begin
            rx_thr <= cfg_wdata[13:8];
            tx_thr <= cfg_wdata[5:0];
        end
    end

    xfer_byte_ring #(.DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push      (h_push_ok || e_push_ok),
        .push_data (host_wr ? host_wdata : eng_wdata),
        .pop       (h_pop_ok || e_pop_ok),
        .head      (head),
        .level     (level),
        .empty     (empty),
        .full      (full)
    );

    xfer_flag_ctrl #(.LW(LW), .CW(CW)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .h_push_ok    (h_push_ok),
        .h_push_err   (h_push_err),
        .h_pop_ok     (h_pop_ok),
        .h_pop_err    (h_pop_err),
        .e_pop_err    (e_pop_err),
        .rx_eval      (eng_rx_done),
        .level        (level),
        .rx_thr       (rx_thr),
        .tx_thr       (tx_thr),
        .xfer_tx      (xfer_tx),
        .xfer_left    (xfer_left),
        .empty        (empty),
        .rx_ready     (rx_ready),
        .rx_drain     (rx_drain),
        .tx_ready     (tx_ready),
        .tx_drain     (tx_drain),
        .acc_ready    (acc_ready),
        .acc_err      (acc_err),
        .tx_underflow (tx_underflow)
    );

    a_r2_full_write_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && full && !clr && !host_rd && !eng_pop) |=> acc_err && $stable(level));
    a_r2_empty_read_errs: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && empty && !host_wr) |=> acc_err);
    a_r10_single_push: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && eng_push && !full && !clr && !host_rd && !eng_pop)
            |=> level == $past(level) + LW'(1));
endmodule

// File: tb/xfer_byte_fifo_tb_top.sv
module xfer_byte_fifo_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0, cfg_wr = 1'b0;
    logic [7:0]  host_wdata = '0, eng_wdata = '0;
    logic [15:0] cfg_wdata = '0, xfer_left = '0;
    logic        eng_push = 1'b0, eng_pop = 1'b0, eng_rx_done = 1'b0, xfer_tx = 1'b0;
    logic [7:0]  host_rdata, eng_rdata;
    logic        rx_ready, rx_drain, tx_ready, tx_drain, acc_ready, acc_err, tx_underflow;
    logic [15:0] buf_status;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xfer_byte_fifo #(.DEPTH(8), .CW(16)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .eng_push(eng_push), .eng_wdata(eng_wdata), .eng_pop(eng_pop), .eng_rdata(eng_rdata),
        .eng_rx_done(eng_rx_done), .xfer_tx(xfer_tx), .xfer_left(xfer_left),
        .rx_ready(rx_ready), .rx_drain(rx_drain), .tx_ready(tx_ready), .tx_drain(tx_drain),
        .acc_ready(acc_ready), .acc_err(acc_err), .tx_underflow(tx_underflow),
        .buf_status(buf_status)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    function automatic int occ;
        return int'(buf_status[13:8]);
    endfunction

    task automatic hwrite(input logic [7:0] b);
        host_wr = 1'b1; host_wdata = b; tick; host_wr = 1'b0;
    endtask

    task automatic hread(output logic [7:0] b);
        host_rd = 1'b1; #1 b = host_rdata; tick; host_rd = 1'b0;
    endtask

    task automatic epush(input logic [7:0] b);
        eng_push = 1'b1; eng_wdata = b; tick; eng_push = 1'b0;
    endtask

    task automatic cfg(input logic [15:0] v);
        cfg_wr = 1'b1; cfg_wdata = v; tick; cfg_wr = 1'b0;
    endtask

    task automatic rxdone;
        eng_rx_done = 1'b1; tick; eng_rx_done = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        // R11 reset state
        chk("R11 status", int'(buf_status), 0);
        chk("R11 flags", int'({rx_ready, rx_drain, tx_ready, tx_drain, acc_ready, acc_err, tx_underflow}), 0);

        // R1 fill to depth, R2 overfill
        for (int i = 0; i < 8; i++) begin
            hwrite(8'hA0 + 8'(i));
            chk("R1 level", occ(), i + 1);
        end
        hwrite(8'hEE);
        chk("R2 full write err", int'(acc_err), 1);
        chk("R2 full write dropped", occ(), 8);
        for (int i = 0; i < 8; i++) begin
            hread(b);
            chk("R1 order", int'(b), 'hA0 + i);
            chk("R2 ok read clears err", int'(acc_err), 0);
        end
        hread(b);
        chk("R2 empty read err", int'(acc_err), 1);
        chk("R2 empty read level", occ(), 0);
        hwrite(8'h11);
        chk("R2 ok write clears err", int'(acc_err), 0);
        hread(b);

        // R1 wrap-around rounds
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 5; i++) epush(8'(r * 16 + i));
            for (int i = 0; i < 5; i++) begin
                hread(b);
                chk("R1 wrap order", int'(b), r * 16 + i);
            end
        end

        // R4 threshold sweep
        for (int thr = 0; thr <= 8; thr++) begin
            for (int n = 0; n <= 8; n++) begin
                cfg(16'(thr << 8) | 16'h4000);
                for (int i = 0; i < n; i++) epush(8'(i));
                rxdone;
                chk("R4 rx_ready", int'(rx_ready), int'(n > thr));
                chk("R4 rx_drain", int'(rx_drain), int'(n <= thr));
            end
        end

        // R5 / R6 read-down sweep
        for (int thr = 0; thr < 8; thr++) begin
            cfg(16'(thr << 8) | 16'h0040);
            for (int i = 0; i < 8; i++) epush(8'(i));
            rxdone;
            chk("R6 rx_done clears acc_ready", int'(acc_ready), 0);
            for (int k = 1; k <= 8; k++) begin
                int rem;
                rem = 8 - k;
                hread(b);
                chk("R5 rx_ready", int'(rx_ready), int'(rem > thr));
                chk("R5 rx_drain", int'(rx_drain), int'(rem > 0 && rem <= thr));
                chk("R6 acc_ready", int'(acc_ready), int'(rem == 0));
            end
        end
        hwrite(8'h33);
        chk("R6 write clears acc_ready", int'(acc_ready), 0);
        cfg(16'h4000);

        // R7 transmit sweep
        xfer_tx = 1'b1;
        for (int thr = 0; thr <= 4; thr++) begin
            cfg(16'(thr));
            for (int left = 0; left <= 8; left++) begin
                xfer_left = 16'(left);
                tick;
                chk("R7 tx_ready", int'(tx_ready), int'(left != 0 && left > thr));
                chk("R7 tx_drain", int'(tx_drain), int'(left != 0 && left <= thr));
            end
        end
        xfer_left = 16'd5;
        hwrite(8'h01);
        tick;
        chk("R7 nonempty no flags", int'({tx_ready, tx_drain}), 0);
        cfg(16'h0040);
        xfer_tx = 1'b0;
        tick;
        chk("R7 receive dir no flags", int'({tx_ready, tx_drain}), 0);

        // R3 underflow
        eng_pop = 1'b1; tick; eng_pop = 1'b0;
        chk("R3 underflow set", int'(tx_underflow), 1);
        hwrite(8'h5A);
        chk("R3 write clears underflow", int'(tx_underflow), 0);
        eng_pop = 1'b1; #1 chk("R3 engine head", int'(eng_rdata), 'h5A); tick; eng_pop = 1'b0;
        chk("R3 engine pop ok", int'(tx_underflow), 0);

        // R8 clears
        for (int i = 0; i < 3; i++) hwrite(8'(i));
        cfg(16'h0000);
        chk("R8 no clear keeps", occ(), 3);
        cfg(16'h0040);
        chk("R8 bit6 clear", occ(), 0);
        for (int i = 0; i < 2; i++) hwrite(8'(i));
        cfg(16'h4000);
        chk("R8 bit14 clear", occ(), 0);

        // R9 status word
        for (int i = 0; i < 5; i++) hwrite(8'(i));
        xfer_left = 16'h1F2A;
        #1 chk("R9 status", int'(buf_status), (5 << 8) | 'h2A);
        cfg(16'h4000);
        xfer_left = 16'h0000;

        // R10 priority
        host_wr = 1'b1; host_wdata = 8'h77; eng_push = 1'b1; eng_wdata = 8'h88;
        tick; host_wr = 1'b0; eng_push = 1'b0;
        chk("R10 one push", occ(), 1);
        chk("R10 host byte", int'(host_rdata), 'h77);
        hwrite(8'h99);
        host_rd = 1'b1; eng_pop = 1'b1; tick; host_rd = 1'b0; eng_pop = 1'b0;
        chk("R10 one pop", occ(), 1);
        chk("R10 next head", int'(host_rdata), 'h99);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule